// File: doc/BRIEF.md
# Debug Instruction Injection Shifter

This block drives a four-wire test access port to place one 32-bit word into the pipeline of a halted processor core. The word is either an instruction or a data value that the core takes off its data bus. The caller gives the word and a breakpoint flag and pulses a start strobe. The block then routes the core's instruction scan chain into the data path and shifts a 33-bit frame. The breakpoint bit goes first, followed by the word, most significant bit first. The block finishes in the idle state of the port controller, so that the core sees one debug clock and takes the word. The 32 bits that come back on TDO during the word part of the shift are returned as the result of the push.

Selecting the chain needs three steps: a chain-select instruction, a 4-bit chain number, then the internal-test instruction. While the core is in debug state it must not be clocked between these steps, so the block goes from each Update state straight to Select-DR. The block records that the selection is in place. Later pushes skip the three steps until a reset or a flush strobe clears that record. The flush is meant for the case where another agent on the same pins may have changed the chain.

A no-operation request replaces the caller's word with the core's no-op encoding. The 16-bit form is used when the core reports compressed-instruction state, and the 32-bit form is used otherwise. The word and breakpoint flag of the last push are held on outputs.

Top module: `jtag_inject`

## Requirements
- R1: While reset is applied and after it is released with no push, busy_o, done_o, tck_o, tms_o, tdi_o and result_o are all zero, and tck_o stays low whenever the block is neither busy nor signalling done.
- R2: Each TCK period takes two clk cycles, low then high. TMS and TDI change only while TCK falls or is low, and TDO is sampled on the clk edge that raises TCK. A push with no cached selection therefore completes 142 clk cycles after the start edge.
- R3: The first push after reset or flush starts with five TCKs with TMS high and one with TMS low. It then loads IR code 0x2 (4 bits, LSB first), shifts chain number 1 through DR (4 bits, LSB first), then loads IR code 0xC. The whole push takes 71 TCKs.
- R4: During selection the port controller is never in Run-Test/Idle once the first Update state has been reached, until the frame's Update-DR has been reached.
- R5: While the selection is cached, a push consists only of the frame scan plus the idle ending, which is 39 TCKs.
- R6: The frame is 33 bits: the breakpoint flag first, then the word from bit 31 down to bit 0.
- R7: The TCK after the frame's Update-DR enters Run-Test/Idle. One further TCK in Run-Test/Idle follows, and on that rising edge done_o pulses high for exactly one clk and busy_o falls.
- R8: result_o holds the 32 TDO bits sampled during the word part of the frame. The first of these bits lands in bit 31. The TDO bit sampled during the breakpoint bit is discarded.
- R9: When nop_i is high, word_i is ignored and the pushed word is 0x000046C0 if thumb_i is high, or 0xE1A00000 if it is low.
- R10: last_word_o and last_brk_o take the pushed word and flag when a start is accepted, and hold them until the next accepted start.
- R11: A start strobe while busy_o is high is ignored. It changes neither the frame, nor the latched word, nor the number of pushes.
- R12: A flush strobe clears the cached selection, so the next push performs the full selection of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a push when idle |
| word_i | input | 32 | Word to push |
| brk_i | input | 1 | Breakpoint flag, shifted first |
| nop_i | input | 1 | Push a no-op instead of word_i |
| thumb_i | input | 1 | Core is in compressed-instruction state |
| sel_flush_i | input | 1 | Forget the cached chain selection |
| busy_o | output | 1 | A push is in progress |
| done_o | output | 1 | One-clk pulse at completion |
| result_o | output | 32 | Word captured from the chain |
| last_word_o | output | 32 | Word of the last accepted push |
| last_brk_o | output | 1 | Breakpoint flag of the last accepted push |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Test mode select |
| tdi_o | output | 1 | Test data to the target |
| tdo_i | input | 1 | Test data from the target |

## Verification
A corrupted segment or bit counter moves the Update states. It shows as a wrong number of TCKs per push, as a wrong IR code or chain number at the target, or as Run-Test/Idle being entered during selection. All of these are visible at the moment of the next done pulse. A stale cache flag appears as 39 TCKs where 71 were due, or the reverse, on the very first push after the flag goes wrong. A slip in the capture enable rotates or shifts result_o, and a wrong frame bit index shows as a misplaced breakpoint bit or a reversed word in the frame taken at Update-DR. Each of these can be seen within the push in which it happens.

// File: rtl/jii_pkg.sv
package jii_pkg;
  typedef enum logic [2:0] {
    SG_OFF, SG_RST, SG_IRSEL, SG_CHAIN, SG_IRMODE, SG_FRAME, SG_IDLE
  } seg_e;

  typedef enum logic [1:0] {
    PT_HEAD, PT_BODY, PT_TAIL
  } part_e;

  localparam int RST_LEN  = 6;  // five TMS-high clocks, then one low
  localparam int IR_HEAD  = 4;  // Select-DR, Select-IR, Capture-IR, enter Shift-IR
  localparam int DR_HEAD  = 3;  // Select-DR, Capture-DR, enter Shift-DR
  localparam int IDLE_LEN = 2;  // enter Run-Test/Idle, one more idle clock
endpackage

// File: rtl/jii_word_sel.sv
module jii_word_sel #(
  parameter int          WORD_W     = 32,
  parameter logic [31:0] NOP_WIDE   = 32'hE1A0_0000,
  parameter logic [15:0] NOP_NARROW = 16'h46C0
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              nop_i,
  input  logic              narrow_i,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [WORD_W-1:0] NARROW_EXT = {{(WORD_W-16){1'b0}}, NOP_NARROW};
  localparam logic [WORD_W-1:0] WIDE_EXT   = NOP_WIDE[WORD_W-1:0];

  always_comb begin
    if (!nop_i)        word_o = word_i;
    else if (narrow_i) word_o = NARROW_EXT;
    else               word_o = WIDE_EXT;
  end
endmodule

// File: rtl/jii_seq.sv
module jii_seq
  import jii_pkg::*;
#(
  parameter int                WORD_W    = 32,
  parameter int                IR_W      = 4,
  parameter int                SEL_W     = 4,
  parameter logic [IR_W-1:0]   IR_SELECT = 4'h2,
  parameter logic [IR_W-1:0]   IR_MODE   = 4'hC,
  parameter logic [SEL_W-1:0]  CHAIN_NO  = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              cached_i,
  input  logic              adv_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              brk_i,
  output logic              tms_o,
  output logic              tdi_o,
  output logic              cap_o,
  output logic              last_o
);
  localparam int CW = $clog2(WORD_W + 2);

  seg_e            seg_q, seg_d;
  part_e           part_q, part_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [CW-1:0]   end_idx;
  logic            at_end;
  logic [IR_W-1:0] ir_sh;
  logic [SEL_W-1:0] sel_sh;
  logic [WORD_W-1:0] w_sh;

  // bit pickers: serial order is LSB first for IR and chain number,
  // MSB first for the frame word (index 1 of the body is word bit WORD_W-1)
  always_comb begin
    ir_sh  = ((seg_q == SG_IRSEL) ? IR_SELECT : IR_MODE) >> cnt_q;
    sel_sh = CHAIN_NO >> cnt_q;
    w_sh   = word_i << (cnt_q - CW'(1));
  end

  // per-clock TMS/TDI for the current position
  always_comb begin
    end_idx = '0;
    tms_o   = 1'b0;
    tdi_o   = 1'b0;
    cap_o   = 1'b0;
    unique case (seg_q)
      SG_RST: begin
        end_idx = CW'(RST_LEN - 1);
        tms_o   = (cnt_q != end_idx);
      end
      SG_IRSEL, SG_IRMODE: begin
        unique case (part_q)
          PT_HEAD: begin end_idx = CW'(IR_HEAD - 1); tms_o = (cnt_q < CW'(2)); end
          PT_BODY: begin
            end_idx = CW'(IR_W - 1);
            tms_o   = (cnt_q == end_idx);
            tdi_o   = ir_sh[0];
          end
          default: begin end_idx = '0; tms_o = 1'b1; end
        endcase
      end
      SG_CHAIN, SG_FRAME: begin
        unique case (part_q)
          PT_HEAD: begin end_idx = CW'(DR_HEAD - 1); tms_o = (cnt_q == '0); end
          PT_BODY: begin
            if (seg_q == SG_CHAIN) begin
              end_idx = CW'(SEL_W - 1);
              tdi_o   = sel_sh[0];
            end else begin
              end_idx = CW'(WORD_W);
              tdi_o   = (cnt_q == '0) ? brk_i : w_sh[WORD_W-1];
              cap_o   = (cnt_q != '0);
            end
            tms_o = (cnt_q == end_idx);
          end
          default: begin end_idx = '0; tms_o = 1'b1; end
        endcase
      end
      SG_IDLE: begin
        end_idx = CW'(IDLE_LEN - 1);
        tms_o   = 1'b0;
      end
      default: end_idx = '0;
    endcase
    at_end = (cnt_q == end_idx);
    last_o = (seg_q == SG_IDLE) && at_end;
  end

  // next position
  always_comb begin
    seg_d  = seg_q;
    part_d = part_q;
    cnt_d  = cnt_q;
    if (go_i) begin
      seg_d  = cached_i ? SG_FRAME : SG_RST;
      part_d = PT_HEAD;
      cnt_d  = '0;
    end else if (adv_i && seg_q != SG_OFF) begin
      if (!at_end) begin
        cnt_d = cnt_q + CW'(1);
      end else begin
        cnt_d = '0;
        unique case (seg_q)
          SG_RST:  begin seg_d = SG_IRSEL; part_d = PT_HEAD; end
          SG_IDLE: seg_d = SG_OFF;
          default: begin
            if (part_q == PT_HEAD)      part_d = PT_BODY;
            else if (part_q == PT_BODY) part_d = PT_TAIL;
            else begin
              part_d = PT_HEAD;
              unique case (seg_q)
                SG_IRSEL:  seg_d = SG_CHAIN;
                SG_CHAIN:  seg_d = SG_IRMODE;
                SG_IRMODE: seg_d = SG_FRAME;
                default:   seg_d = SG_IDLE;
              endcase
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SG_OFF;
      part_q <= PT_HEAD;
      cnt_q  <= '0;
    end else begin
      seg_q  <= seg_d;
      part_q <= part_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/jii_capture.sv
module jii_capture #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sh_q <= '0;
    else if (en_i) sh_q <= sh_d;
  end

  assign word_o = sh_q;
endmodule

// File: rtl/jtag_inject.sv
module jtag_inject #(
  parameter int          WORD_W     = 32,
  parameter int          IR_W       = 4,
  parameter int          SEL_W      = 4,
  parameter logic [3:0]  IR_SELECT  = 4'h2,
  parameter logic [3:0]  IR_MODE    = 4'hC,
  parameter logic [3:0]  CHAIN_NO   = 4'h1,
  parameter logic [31:0] NOP_WIDE   = 32'hE1A0_0000,
  parameter logic [15:0] NOP_NARROW = 16'h46C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              brk_i,
  input  logic              nop_i,
  input  logic              thumb_i,
  input  logic              sel_flush_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] result_o,
  output logic [WORD_W-1:0] last_word_o,
  output logic              last_brk_o,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  input  logic              tdo_i
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic              busy_q, busy_d;
  logic              ph_q, ph_d;
  logic              tck_q, tck_d, tms_q, tms_d, tdi_q, tdi_d;
  logic              done_q, done_d;
  logic              cache_q, cache_d;
  logic [WORD_W-1:0] lword_q, lword_d, sel_word;
  logic              lbrk_q, lbrk_d;
  logic              accept, adv, fin, use_cache;
  logic              seq_tms, seq_tdi, seq_cap, seq_last;

  jii_word_sel #(
    .WORD_W(WORD_W), .NOP_WIDE(NOP_WIDE), .NOP_NARROW(NOP_NARROW)
  ) u_wsel (
    .word_i(word_i), .nop_i(nop_i), .narrow_i(thumb_i), .word_o(sel_word)
  );

  jii_seq #(
    .WORD_W(WORD_W), .IR_W(IR_W), .SEL_W(SEL_W),
    .IR_SELECT(IR_SELECT[IR_W-1:0]), .IR_MODE(IR_MODE[IR_W-1:0]),
    .CHAIN_NO(CHAIN_NO[SEL_W-1:0])
  ) u_seq (
    .clk(clk), .rst_n(rst_core_n), .go_i(accept), .cached_i(use_cache),
    .adv_i(adv), .word_i(lword_q), .brk_i(lbrk_q),
    .tms_o(seq_tms), .tdi_o(seq_tdi), .cap_o(seq_cap), .last_o(seq_last)
  );

  jii_capture #(.WORD_W(WORD_W)) u_cap (
    .clk(clk), .rst_n(rst_core_n), .en_i(adv & seq_cap), .bit_i(tdo_i),
    .word_o(result_o)
  );

  always_comb begin
    accept    = start_i & ~busy_q;
    use_cache = cache_q & ~sel_flush_i;
    adv       = busy_q & ph_q;
    fin       = adv & seq_last;

    busy_d  = accept | (busy_q & ~fin);
    ph_d    = (busy_q & ~accept) ? ~ph_q : 1'b0;
    done_d  = fin;
    cache_d = sel_flush_i ? 1'b0 : (fin ? 1'b1 : cache_q);
    lword_d = accept ? sel_word : lword_q;
    lbrk_d  = accept ? brk_i : lbrk_q;

    if (busy_q && !ph_q) begin        // low phase: launch the next bit
      tck_d = 1'b0;
      tms_d = seq_tms;
      tdi_d = seq_tdi;
    end else if (busy_q) begin        // high phase: rising edge, hold data
      tck_d = 1'b1;
      tms_d = tms_q;
      tdi_d = tdi_q;
    end else begin
      tck_d = 1'b0;
      tms_d = 1'b0;
      tdi_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      busy_q  <= 1'b0;
      ph_q    <= 1'b0;
      tck_q   <= 1'b0;
      tms_q   <= 1'b0;
      tdi_q   <= 1'b0;
      done_q  <= 1'b0;
      cache_q <= 1'b0;
      lword_q <= '0;
      lbrk_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      ph_q    <= ph_d;
      tck_q   <= tck_d;
      tms_q   <= tms_d;
      tdi_q   <= tdi_d;
      done_q  <= done_d;
      cache_q <= cache_d;
      lword_q <= lword_d;
      lbrk_q  <= lbrk_d;
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign tck_o       = tck_q;
  assign tms_o       = tms_q;
  assign tdi_o       = tdi_q;
  assign last_word_o = lword_q;
  assign last_brk_o  = lbrk_q;
endmodule

// File: rtl/jtag_inject_chk.sv
module jtag_inject_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              tck_o,
  input logic              tms_o,
  input logic              tdi_o,
  input logic [WORD_W-1:0] last_word_o,
  input logic              last_brk_o
);
  // R1: the test clock is quiet outside a push
  p_quiet_tck_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o) |-> !tck_o);

  // R2: data lines never move on the rising edge of TCK
  p_rise_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck_o) |-> ($stable(tms_o) && $stable(tdi_o)));

  // R2: TCK high lasts exactly one clk
  p_tck_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck_o) |=> $fell(tck_o));

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: done arrives on a rising TCK in idle, with the block no longer busy
  p_done_at_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && tck_o && !tms_o));

  // R10, R11: latched word and flag hold for the whole push
  p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(last_word_o) && $stable(last_brk_o)));
endmodule

bind jtag_inject jtag_inject_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o),
  .last_word_o(last_word_o), .last_brk_o(last_brk_o)
);

// File: tb/jtag_inject_bench.sv
`timescale 1ns/1ps
module jtag_inject_bench;
  localparam logic [3:0]  C_SELECT = 4'h2;
  localparam logic [3:0]  C_MODE   = 4'hC;
  localparam logic [3:0]  C_CHAIN  = 4'h1;
  localparam logic [31:0] C_NOPW   = 32'hE1A0_0000;
  localparam logic [31:0] C_NOPN   = 32'h0000_46C0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, brk_i = 1'b0, nop_i = 1'b0, thumb_i = 1'b0;
  logic        sel_flush_i = 1'b0;
  logic [31:0] word_i = '0;
  logic        busy_o, done_o, last_brk_o, tck_o, tms_o, tdi_o, tdo_i;
  logic [31:0] result_o, last_word_o;

  always #2.5 clk = ~clk;

  jtag_inject u_jtag_inject (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
    .brk_i(brk_i), .nop_i(nop_i), .thumb_i(thumb_i), .sel_flush_i(sel_flush_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .last_word_o(last_word_o), .last_brk_o(last_brk_o),
    .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o), .tdo_i(tdo_i)
  );

  int tests = 0, fails = 0, cyc = 0, t0 = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // ---------------- target TAP model ----------------
  typedef enum logic [3:0] {TLR, RTI, SDR, CDR, SHDR, E1DR, PDR, E2DR, UDR,
                            SIR, CIR, SHIR, E1IR, PIR, E2IR, UIR} tap_e;
  tap_e        st = TLR;
  logic [3:0]  ir = 4'hE, ir_sr = '0, chain = '0, sc_sr = '0;
  logic [32:0] f_sr = '0, cap_val = '0;
  int          n_tck = 0, after_cnt = 0;
  bit          sel_started = 0, frame_done = 0;
  int          rti_bad = 0;
  logic [31:0] f_word = '0;
  logic        f_brk = 1'b0;

  function automatic tap_e tap_next(tap_e s, logic m);
    case (s)
      TLR:  return m ? TLR  : RTI;
      RTI:  return m ? SDR  : RTI;
      SDR:  return m ? SIR  : CDR;
      CDR:  return m ? E1DR : SHDR;
      SHDR: return m ? E1DR : SHDR;
      E1DR: return m ? UDR  : PDR;
      PDR:  return m ? E2DR : PDR;
      E2DR: return m ? UDR  : SHDR;
      UDR:  return m ? SDR  : RTI;
      SIR:  return m ? TLR  : CIR;
      CIR:  return m ? E1IR : SHIR;
      SHIR: return m ? E1IR : SHIR;
      E1IR: return m ? UIR  : PIR;
      PIR:  return m ? E2IR : PIR;
      E2IR: return m ? UIR  : SHIR;
      default: return m ? SDR : RTI;
    endcase
  endfunction

  wire chain1_sel = (ir == C_MODE) && (chain == C_CHAIN);
  assign tdo_i = (st == SHDR && chain1_sel) ? f_sr[0] : 1'b0;

  always @(posedge tck_o) begin
    n_tck++;
    if (frame_done) after_cnt++;
    if (st == RTI && sel_started && !frame_done) rti_bad++;
    case (st)
      TLR:  begin ir = 4'hE; chain = '0; end
      CIR:  ir_sr = 4'h1;
      SHIR: ir_sr = {tdi_o, ir_sr[3:1]};
      UIR:  begin ir = ir_sr; sel_started = 1; end
      CDR:  if (chain1_sel) f_sr = cap_val;
      SHDR: begin
        if (ir == C_SELECT) sc_sr = {tdi_o, sc_sr[3:1]};
        else if (chain1_sel) f_sr = {tdi_o, f_sr[32:1]};
      end
      UDR: begin
        sel_started = 1;
        if (ir == C_SELECT) chain = sc_sr;
        else if (chain1_sel) begin
          frame_done = 1;
          f_brk = f_sr[0];
          for (int i = 0; i < 32; i++) f_word[31-i] = f_sr[i+1];
        end
      end
      default: ;
    endcase
    st = tap_next(st, tms_o);
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [31:0] word;
    logic        brk;
    int          ntck;
    logic [32:0] cap;
  } item_t;
  item_t q[$];
  bit    cache_exp = 1'b0;

  task automatic push(input logic [31:0] w, input logic b, input logic nop,
                      input logic th, input logic [32:0] cap);
    item_t it;
    @(negedge clk);
    word_i = w; brk_i = b; nop_i = nop; thumb_i = th;
    cap_val = cap;
    n_tck = 0; after_cnt = 0; sel_started = 0; frame_done = 0; rti_bad = 0;
    it.word = !nop ? w : (th ? C_NOPN : C_NOPW);   // R9
    it.brk  = b;
    it.ntck = cache_exp ? 39 : 71;                 // R3, R5
    it.cap  = cap;
    q.push_back(it);
    cache_exp = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    t0 = cyc;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (busy_o || q.size() != 0) @(negedge clk);
  endtask

  initial begin : monitor
    item_t it;
    logic [31:0] er;
    forever begin
      @(negedge clk);
      if (done_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R11 done without a push", 1, 0);
        end else begin
          it = q.pop_front();
          for (int i = 0; i < 32; i++) er[31-i] = it.cap[i+1];
          chk(result_o == er, "R8 result", result_o, er);
          chk(f_word == it.word, "R6/R9 frame word", f_word, it.word);
          chk(f_brk == it.brk, "R6 frame breakpoint bit", f_brk, it.brk);
          chk(n_tck == it.ntck, "R3/R5 TCK count", n_tck, it.ntck);
          chk(rti_bad == 0, "R4 idle during selection", rti_bad, 0);
          chk(ir == C_MODE && chain == C_CHAIN, "R3 selection",
              {ir, chain}, {C_MODE, C_CHAIN});
          chk(st == RTI && after_cnt == 1, "R7 idle ending",
              {st, 8'(after_cnt)}, {RTI, 8'd1});
          chk(cyc - t0 == 2 * it.ntck, "R2 clk per push", cyc - t0, 2 * it.ntck);
          chk(last_word_o == it.word && last_brk_o == it.brk, "R10 latch",
              {last_brk_o, last_word_o}, {it.brk, it.word});
          chk(!busy_o, "R7 busy falls with done", busy_o, 0);
          @(negedge clk);
          chk(!done_o, "R7 done single pulse", done_o, 0);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL R7 watchdog: no completion actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    // R1: reset state, while held and after release
    chk({busy_o, done_o, tck_o, tms_o, tdi_o} == '0, "R1 outputs in reset",
        {busy_o, done_o, tck_o, tms_o, tdi_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(result_o == '0 && !busy_o && !tck_o, "R1 idle after reset",
        result_o, 0);

    push(32'h1234_5678, 1'b0, 1'b0, 1'b0, 33'h1_DEAD_BEEF);   // R3 uncached
    wait_idle();
    push(32'h8000_0001, 1'b1, 1'b0, 1'b0, 33'h0_F0F0_3C3C);   // R5 cached, R6
    wait_idle();
    push(32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 33'h1_8000_0001);   // R9 wide no-op
    wait_idle();
    push(32'h0BAD_F00D, 1'b1, 1'b1, 1'b1, 33'h0_0000_0001);   // R9 narrow no-op
    wait_idle();

    // R12: flush forces full selection again
    @(negedge clk); sel_flush_i = 1'b1;
    @(negedge clk); sel_flush_i = 1'b0;
    cache_exp = 1'b0;
    push(32'h0000_0000, 1'b1, 1'b0, 1'b0, 33'h1_FFFF_FFFF);
    wait_idle();

    // R11: a second start during a push is ignored
    push(32'hA5A5_5A5A, 1'b0, 1'b0, 1'b0, 33'h0_1357_9BDF);
    repeat (20) @(negedge clk);
    word_i = 32'h1111_2222; brk_i = 1'b1; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk);
    chk(!busy_o && last_word_o == 32'hA5A5_5A5A, "R11 start while busy ignored",
        {busy_o, last_word_o}, {1'b0, 32'hA5A5_5A5A});
    chk(!tck_o && !tms_o, "R1 quiet after push", {tck_o, tms_o}, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule